// File: doc/BRIEF.md
# Masked GPIO Port with Grouped Direction Control

This block is a 32-bit general-purpose I/O port driven through a strobed write/read register interface. Software raises selected output bits with a set operation and lowers them with a clear operation. Either operation acts only on bits that are outputs at that moment. Software can read back the synchronized pin values, the output shadow, the input-capable map and the output map. It also asks for bits to become inputs or outputs.

Direction does not change per bit. Only bits that are both input-capable and output-capable, and that also lie within the fixed eligible mask 0x01FFFF01, can switch direction. Bit 0 and bit 24 each switch on their own. Bits 8–15 and bits 16–23 each switch only as a whole byte. Effective direction writes are kept a minimum number of clock cycles apart. A request that arrives too early is parked in a one-entry slot and applied as soon as the interval has passed. While a request is parked or the interval is running, a busy flag is raised.

The port drives pad output data from the shadow and pad output enables from the output map.

Top module: `gpio_port`

## Requirements
- R1: After reset the input map equals IN_CAP, the output map equals OUT_CAP with the changeable bits cleared, the shadow is zero and busy is 0. The changeable bits are 0x01FFFF01 & IN_CAP & OUT_CAP.
- R2: Bits outside the changeable set never change direction. A request that names only such bits has no effect.
- R3: A make-input (wr_op=2) or make-output (wr_op=3) request switches bit 0 when bit 0 is requested and bit 24 when bit 24 is requested, each independently of the other bits.
- R4: Bits 8–15 switch only when all eight are in the request, and the same holds for bits 16–23. A partial byte leaves that group unchanged, so each byte group is always wholly input or wholly output.
- R5: A direction request takes effect only if it names at least one bit that is not already in the target direction and at least one changeable bit. Otherwise nothing changes and the spacing timer is not started.
- R6: Set (wr_op=0) ORs wr_data into the shadow and clear (wr_op=1) clears the wr_data bits, in both cases only for bits that are currently outputs. Other requested bits are ignored.
- R7: Read-back values (rd_sel 0 = pins, 1 = shadow, 2 = input map, 3 = output map, 4 = status with busy in bit 0) always have bit 31 at 0. In the output map a 1 marks an output, and bits that are both input and output read 1 in both maps.
- R8: Two effective direction writes are at least CFG_GAP cycles apart. An earlier write parks the request, raises busy, and is applied exactly CFG_GAP cycles after the previous application.
- R9: pad_in reaches the pin read-back through two flops, so a change is visible two clock edges later.
- R10: pad_out carries the shadow and pad_oe carries the output map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_op | input | 2 | 0 set, 1 clear, 2 make input, 3 make output |
| wr_data | input | 32 | Bit mask for the operation |
| rd_sel | input | 3 | Read-back selector |
| rd_data | output | 32 | Selected read-back value |
| pad_in | input | 32 | Pin values from the pads |
| pad_out | output | 32 | Output data to the pads |
| pad_oe | output | 32 | Output enables to the pads (1 = drive) |
| cfg_busy | output | 1 | Direction spacing running or request parked |

## Verification
The assertions assume that reset is held for at least two clock edges, so that the two-cycle pin lag check never compares against unsynchronized history. They also assume that wr_en is a clean one-cycle strobe whose wr_op value is sampled only in that cycle. The bench drives every input on the falling clock edge and keeps reset high for four cycles. It issues each write as a single-cycle pulse. Outside the pacing scenario, it waits out the full spacing interval between direction writes.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int PORT_W = 32;
    localparam logic [PORT_W-1:0] DIR_ELIGIBLE = 32'h01FF_FF01;
    localparam logic [PORT_W-1:0] RD_MASK      = 32'h7FFF_FFFF;
    localparam int SOLO_LO   = 0;
    localparam int SOLO_HI   = 24;
    localparam int GRP_FIRST = 1;
    localparam int GRP_LAST  = 2;

    typedef enum logic [1:0] {
        WR_SET   = 2'd0,
        WR_CLR   = 2'd1,
        WR_MKIN  = 2'd2,
        WR_MKOUT = 2'd3
    } wr_op_e;

    typedef enum logic [2:0] {
        RD_PINS   = 3'd0,
        RD_SHADOW = 3'd1,
        RD_INMAP  = 3'd2,
        RD_OUTMAP = 3'd3,
        RD_STATUS = 3'd4
    } rd_sel_e;

    typedef struct packed {
        logic              valid;
        logic              to_out;
        logic [PORT_W-1:0] bits;
    } dir_req_t;

    // Bits that a request actually moves: solo bits individually, bytes only whole.
    function automatic logic [PORT_W-1:0] group_switch(
        input logic [PORT_W-1:0] req,
        input logic [PORT_W-1:0] chg
    );
        logic [PORT_W-1:0] m;
        logic [PORT_W-1:0] sw;
        m  = req & chg;
        sw = '0;
        if (m[SOLO_LO]) sw[SOLO_LO] = 1'b1;
        if (m[SOLO_HI]) sw[SOLO_HI] = 1'b1;
        for (int g = GRP_FIRST; g <= GRP_LAST; g++) begin
            if (&m[g*8 +: 8]) sw[g*8 +: 8] = 8'hFF;
        end
        return sw & chg;
    endfunction

    function automatic logic request_effective(
        input logic [PORT_W-1:0] req,
        input logic [PORT_W-1:0] target_map,
        input logic [PORT_W-1:0] chg
    );
        return ((req & target_map) != req) && ((req & chg) != '0);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= d;
        sync_q <= meta_q;
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_shadow.sv
`timescale 1ns/1ps
module gpio_shadow
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              do_set,
    input  logic              do_clr,
    input  logic [PORT_W-1:0] mask,
    input  logic [PORT_W-1:0] out_map,
    output logic [PORT_W-1:0] shadow
);
    logic [PORT_W-1:0] shadow_q;
    logic [PORT_W-1:0] eff;

    assign eff = mask & out_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (do_set) begin
            shadow_q <= shadow_q | eff;
        end else if (do_clr) begin
            shadow_q <= shadow_q & ~eff;
        end
    end

    assign shadow = shadow_q;

    // R6
    shadow_outonly_chk: assert property (@(posedge clk) disable iff (rst)
        ((shadow_q ^ $past(shadow_q)) & ~$past(out_map)) == '0);
endmodule

// File: rtl/gpio_dir_ctrl.sv
`timescale 1ns/1ps
module gpio_dir_ctrl
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] IN_CAP  = 32'h11FF_FF0E,
    parameter logic [PORT_W-1:0] OUT_CAP = 32'hFFFF_FF01,
    parameter int                GAP     = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_to_out,
    input  logic [PORT_W-1:0] req_bits,
    output logic [PORT_W-1:0] in_map,
    output logic [PORT_W-1:0] out_map,
    output logic              busy
);
    localparam logic [PORT_W-1:0] CHG = DIR_ELIGIBLE & IN_CAP & OUT_CAP;
    localparam int CW = $clog2(GAP + 1);

    logic [PORT_W-1:0] in_q, out_q;
    logic [CW-1:0]     cnt_q;
    dir_req_t          pend_q, cur;
    logic              slot_free, take_pend, take_new, fire, accept;
    logic [PORT_W-1:0] sw;

    assign slot_free = (cnt_q == '0);
    assign take_pend = slot_free && pend_q.valid;
    assign take_new  = slot_free && !pend_q.valid && req_valid;
    assign fire      = take_pend || take_new;

    always_comb begin
        if (take_pend) begin
            cur = pend_q;
        end else begin
            cur.valid  = req_valid;
            cur.to_out = req_to_out;
            cur.bits   = req_bits;
        end
        sw     = group_switch(cur.bits, CHG);
        accept = fire && request_effective(cur.bits, cur.to_out ? out_q : in_q, CHG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= IN_CAP;
            out_q  <= OUT_CAP & ~CHG;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (accept) begin
                if (cur.to_out) begin
                    out_q <= out_q | sw;
                    in_q  <= in_q & ~sw;
                end else begin
                    in_q  <= in_q | sw;
                    out_q <= out_q & ~sw;
                end
                cnt_q <= CW'(GAP - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (req_valid && !take_new) begin
                pend_q.valid  <= 1'b1;
                pend_q.to_out <= req_to_out;
                pend_q.bits   <= req_bits;
            end else if (take_pend) begin
                pend_q.valid <= 1'b0;
            end
        end
    end

    assign in_map  = in_q;
    assign out_map = out_q;
    assign busy    = (cnt_q != '0) || pend_q.valid;

    // Independent spacing monitor: cycles since the last effective write.
    logic [CW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= CW'(GAP);
        end else if (accept) begin
            since_q <= CW'(1);
        end else if (since_q < CW'(GAP)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R8
    cfg_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (since_q >= CW'(GAP)));

    // R2
    fixed_dir_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(out_q & ~CHG) && $stable(in_q & ~CHG));

    generate
        for (genvar g = GRP_FIRST; g <= GRP_LAST; g++) begin : g_grp
            if (&CHG[g*8 +: 8]) begin : g_full
                // R4
                grp_whole_chk: assert property (@(posedge clk) disable iff (rst)
                    (out_q[g*8 +: 8] == 8'h00) || (out_q[g*8 +: 8] == 8'hFF));
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter logic [31:0] IN_CAP  = 32'h11FF_FF0E,
    parameter logic [31:0] OUT_CAP = 32'hFFFF_FF01,
    parameter int          CFG_GAP = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_op,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic [31:0] pad_in,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe,
    output logic        cfg_busy
);
    wr_op_e            op;
    logic [PORT_W-1:0] pins_sync, shadow, in_map, out_map;
    logic              busy;
    logic              dir_req;

    assign op      = wr_op_e'(wr_op);
    assign dir_req = wr_en && ((op == WR_MKIN) || (op == WR_MKOUT));

    gpio_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_dir_ctrl #(
        .IN_CAP  (IN_CAP),
        .OUT_CAP (OUT_CAP),
        .GAP     (CFG_GAP)
    ) u_dir (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (dir_req),
        .req_to_out (op == WR_MKOUT),
        .req_bits   (wr_data),
        .in_map     (in_map),
        .out_map    (out_map),
        .busy       (busy)
    );

    gpio_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .do_set  (wr_en && (op == WR_SET)),
        .do_clr  (wr_en && (op == WR_CLR)),
        .mask    (wr_data),
        .out_map (out_map),
        .shadow  (shadow)
    );

    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_PINS:   rd_data = pins_sync & RD_MASK;
            RD_SHADOW: rd_data = shadow & RD_MASK;
            RD_INMAP:  rd_data = in_map & RD_MASK;
            RD_OUTMAP: rd_data = out_map & RD_MASK;
            RD_STATUS: rd_data = PORT_W'(busy);
            default:   rd_data = '0;
        endcase
    end

    assign pad_out  = shadow;
    assign pad_oe   = out_map;
    assign cfg_busy = busy;

    // R9
    pin_lag_chk: assert property (@(posedge clk) disable iff (rst)
        pins_sync == $past(pad_in, 2));
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
    localparam int GAP = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = 2'd0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        cfg_busy;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.CFG_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .cfg_busy(cfg_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; pulses wr_en across one rising edge.
    task automatic wr(input logic [1:0] op, input logic [31:0] data);
        wr_en = 1'b1; wr_op = op; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic settle();
        repeat (GAP + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd2, v); check("R1 in map", v, 32'h11FF_FF0E);
        rd(3'd3, v); check("R1 out map", v, 32'h7E00_0001);
        rd(3'd1, v); check("R1 shadow", v, 32'h0);
        rd(3'd4, v); check("R1 status", v, 32'h0);
        check("R10 pad_oe reset", pad_oe, 32'hFE00_0001);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R7 shadow bit31 masked", v, 32'h7E00_0001);
        check("R6 set outputs only", pad_out, 32'hFE00_0001);
        @(negedge clk);
        wr(2'd1, 32'h0200_0001);
        check("R6 clear", pad_out, 32'hFC00_0000);
        @(negedge clk);
        wr(2'd0, 32'h0000_0F00);
        check("R6 set on inputs ignored", pad_out, 32'hFC00_0000);
    endtask

    task automatic t_solo();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd3, 32'h0100_0000);
        rd(3'd3, v); check("R3 bit24 out", v, 32'h7F00_0001);
        rd(3'd2, v); check("R3 bit24 not in", v, 32'h10FF_FF0E);
        check("R10 pad_oe follows map", pad_oe, 32'hFF00_0001);
        settle();
    endtask

    task automatic t_partial();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd3, 32'h007F_FF00);
        rd(3'd3, v); check("R4 full byte moves, partial stays", v, 32'h7F00_FF01);
        rd(3'd2, v); check("R4 in map", v, 32'h10FF_000E);
        settle();
    endtask

    task automatic t_no_effect();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd3, 32'h0000_FF00);
        rd(3'd4, v); check("R5 already-out no timer", v, 32'h0);
        rd(3'd3, v); check("R5 out unchanged", v, 32'h7F00_FF01);
        @(negedge clk);
        wr(2'd2, 32'h0000_0001);
        rd(3'd2, v); check("R2 bit0 fixed", v, 32'h10FF_000E);
        rd(3'd4, v); check("R2 no timer", v, 32'h0);
        @(negedge clk);
        wr(2'd2, 32'h1000_0002);
        rd(3'd2, v); check("R7 dual bit28 in map", v, 32'h10FF_000E);
        rd(3'd3, v); check("R7 dual bit28 out map", v, 32'h7F00_FF01);
    endtask

    task automatic t_pacing();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd3, 32'h00FF_0000);
        check("R8 busy after apply", {31'd0, cfg_busy}, 32'h1);
        wr(2'd2, 32'h0000_FF00);
        rd(3'd4, v); check("R8 parked busy", v, 32'h1);
        repeat (GAP - 2) @(negedge clk);
        rd(3'd3, v); check("R8 not yet applied", v, 32'h7FFF_FF01);
        @(negedge clk);
        rd(3'd3, v); check("R8 applied at gap", v, 32'h7FFF_0001);
        rd(3'd2, v); check("R8 in map after", v, 32'h1000_FF0E);
        settle();
        check("R8 busy clears", {31'd0, cfg_busy}, 32'h0);
    endtask

    task automatic t_set_after_dir();
        logic [31:0] v;
        @(negedge clk);
        wr(2'd0, 32'h0000_FFFF);
        check("R6 set after byte to input", pad_out, 32'hFC00_0001);
        @(negedge clk);
        wr(2'd0, 32'h00FF_0000);
        rd(3'd1, v); check("R6 set new outputs", v, 32'h7CFF_0001);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'hA5A5_5A5A;
        @(negedge clk);
        rd(3'd0, v); check("R9 one edge old", v, 32'h0);
        @(negedge clk);
        rd(3'd0, v); check("R9 two edges new", v, 32'h25A5_5A5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_solo();
        t_partial();
        t_no_effect();
        t_pacing();
        t_set_after_dir();
        t_sync();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule